// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Capture

This block controls 64 general-purpose pins, split into two banks of 32 pins. Software reaches it through a simple 32-bit register port with byte offsets. Every register is one 32-bit word. For each feature there is one word per bank. The word for pin `n` sits at the feature's base plus `(n/32)*4`, and the pin's bit within that word is `n mod 32`.

For each pin, software sets three things:
- whether the pin drives (output enable) and the value it drives;
- whether the pin raises events, and how it is triggered: by level or by edge, active-high or active-low;
- four sets of interrupt enables. Only the first set gates the interrupt output.

Pad inputs pass through a two-flop synchronizer before any detection. A sticky status word records events, and software clears it by writing 1s. A single interrupt line is high whenever an enabled pin has a status bit set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all registers read zero. `pad_oe`, `pad_out` and `irq` are all low. Every pin is therefore an input with an active-high level trigger.
- R2: Byte offsets (bank 0 / bank 1) are as follows. Output enable 0x00/0x04. Drive value 0x08/0x0C. Enable sets one to four 0x18/0x1C, 0x20/0x24, 0x28/0x2C and 0x30/0x34. Polarity 0x38/0x3C. Type 0x40/0x44. Status 0x48/0x4C. Pin `n` maps to bit `n mod 32` of bank `n/32`. `rdata` is combinational from `addr` in the same cycle. Address bits [1:0] are ignored.
- R3: `pad_oe` bit `n` equals the output-enable bit for pin `n`, where 1 means output. `pad_out` bit `n` equals the drive-value bit for pin `n`. Both follow a write on the clock edge that takes the write.
- R4: A change on `pad_in` reaches the status register on the third rising clock edge at which the new value is present: two synchronizer stages, then detection.
- R5: A type bit of 0 selects level triggering and 1 selects edge triggering. A polarity bit of 0 selects a rising edge or high level; 1 selects a falling edge or low level.
- R6: In edge mode a status bit sets on a qualifying edge of the synchronized input. It then stays set until a status write with a 1 in that bit. Writing 0 bits leaves status unchanged.
- R7: In level mode a status bit follows the active level one clock after the synchronized input. A clearing write while the level is still active leaves the bit set.
- R8: `irq` is the OR over all pins of (status AND first-set enable). Enable sets two to four are storage only and never affect `irq`.
- R9: If a clearing write and a qualifying edge hit the same pin in the same cycle, the status bit stays set.
- R10: Reads of unmapped offsets (0x10, 0x14 and 0x50 and above) return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 64 | Raw pad input levels, asynchronous |
| pad_oe | output | 64 | Per-pin output enable to the pads |
| pad_out | output | 64 | Per-pin value driven to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted status flop is visible on the next status read. If its first-set enable is on, it is also visible on `irq` in the same cycle. A wrong synchronizer depth makes every event land one edge early or late against the three-edge window. That window is checked on a single pin, cycle by cycle.

A status bit that loses its hold in edge mode, or that misses the clear-versus-edge priority, differs from the bench model on the first read after the event. A decoder fault shows up in two places:
- on the readback of the wrong offset;
- on `pad_oe` or `pad_out` one edge after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS      = 64;
    localparam int BANK_BITS = 32;
    localparam int NBANK     = PINS / BANK_BITS;
    localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int NCFG      = 8;   // features held as plain storage
    localparam int NFEAT     = 9;   // storage features plus status

    typedef enum logic [3:0] {
        F_OE   = 4'd0,
        F_DRV  = 4'd1,
        F_EN0  = 4'd2,
        F_EN1  = 4'd3,
        F_EN2  = 4'd4,
        F_EN3  = 4'd5,
        F_POL  = 4'd6,
        F_TYP  = 4'd7,
        F_STAT = 4'd8
    } feat_e;

    typedef struct packed {
        logic              hit;
        feat_e             feat;
        logic [BANK_W-1:0] bank;
    } dec_t;

    // first word index (byte offset / 4) of each feature
    function automatic int feat_base(input int f);
        case (f)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            3:       return 8;
            4:       return 10;
            5:       return 12;
            6:       return 14;
            7:       return 16;
            default: return 18;
        endcase
    endfunction

    function automatic dec_t decode_word(input int word);
        dec_t d;
        d = '0;
        for (int f = 0; f < NFEAT; f++) begin
            if (word >= feat_base(f) && word < feat_base(f) + NBANK) begin
                d.hit  = 1'b1;
                d.feat = feat_e'(f);
                d.bank = BANK_W'(word - feat_base(f));
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] last
);
    logic [WIDTH-1:0] stg_q [DEPTH];
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) stg_q[s] <= '0;
            last_q <= '0;
        end else begin
            stg_q[0] <= raw;
            for (int s = 1; s < DEPTH; s++) stg_q[s] <= stg_q[s-1];
            last_q <= stg_q[DEPTH-1];
        end
    end

    assign cur  = stg_q[DEPTH-1];
    assign last = last_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] last,
    input  logic [WIDTH-1:0] typ,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] stat,
    output logic [WIDTH-1:0] act,
    output logic [WIDTH-1:0] hit
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic act_now, act_was, st_q;
            assign act_now = cur[i] ^ pol[i];
            assign act_was = last[i] ^ pol[i];
            assign act[i]  = act_now;
            assign hit[i]  = act_now & ~act_was;

            always_ff @(posedge clk) begin
                if (rst)         st_q <= 1'b0;
                else if (typ[i]) st_q <= hit[i] | (st_q & ~clr[i]);
                else             st_q <= act_now;
            end
            assign stat[i] = st_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [PINS-1:0]   stat,
    output logic [31:0]       rdata,
    output logic [PINS-1:0]   oe,
    output logic [PINS-1:0]   drv,
    output logic [PINS-1:0]   en0,
    output logic [PINS-1:0]   pol,
    output logic [PINS-1:0]   typ,
    output logic [PINS-1:0]   clr
);
    logic [31:0] cfg_q [NCFG][NBANK];
    dec_t        dec;
    logic        unused_lsb;

    assign unused_lsb = ^addr[1:0];
    assign dec        = decode_word(int'(addr[ADDR_W-1:2]));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NCFG; f++)
                for (int b = 0; b < NBANK; b++)
                    cfg_q[f][b] <= '0;
        end else if (wr_en && dec.hit && dec.feat != F_STAT) begin
            cfg_q[dec.feat[2:0]][dec.bank] <= wdata;
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign oe [b*BANK_BITS +: BANK_BITS] = cfg_q[int'(F_OE)][b];
            assign drv[b*BANK_BITS +: BANK_BITS] = cfg_q[int'(F_DRV)][b];
            assign en0[b*BANK_BITS +: BANK_BITS] = cfg_q[int'(F_EN0)][b];
            assign pol[b*BANK_BITS +: BANK_BITS] = cfg_q[int'(F_POL)][b];
            assign typ[b*BANK_BITS +: BANK_BITS] = cfg_q[int'(F_TYP)][b];
            assign clr[b*BANK_BITS +: BANK_BITS] =
                (wr_en && dec.hit && dec.feat == F_STAT && dec.bank == BANK_W'(b))
                ? wdata : '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            for (int b = 0; b < NBANK; b++) begin
                if (int'(dec.bank) == b) begin
                    if (dec.feat == F_STAT) rdata = stat[b*BANK_BITS +: BANK_BITS];
                    else                    rdata = cfg_q[dec.feat[2:0]][b];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic              irq
);
    logic [PINS-1:0] sync_cur, sync_last;
    logic [PINS-1:0] en0_w, pol_w, typ_w, clr_w;
    logic [PINS-1:0] stat_w, act_w, hit_w;

    gpio_in_sync #(.WIDTH(PINS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (pad_in),
        .cur  (sync_cur),
        .last (sync_last)
    );

    gpio_trig_detect #(.WIDTH(PINS)) u_det (
        .clk  (clk),
        .rst  (rst),
        .cur  (sync_cur),
        .last (sync_last),
        .typ  (typ_w),
        .pol  (pol_w),
        .clr  (clr_w),
        .stat (stat_w),
        .act  (act_w),
        .hit  (hit_w)
    );

    gpio_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .stat  (stat_w),
        .rdata (rdata),
        .oe    (pad_oe),
        .drv   (pad_out),
        .en0   (en0_w),
        .pol   (pol_w),
        .typ   (typ_w),
        .clr   (clr_w)
    );

    assign irq = |(stat_w & en0_w);
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic              irq,
    input logic [PINS-1:0]   stat_w,
    input logic [PINS-1:0]   typ_w,
    input logic [PINS-1:0]   clr_w,
    input logic [PINS-1:0]   act_w,
    input logic [PINS-1:0]   hit_w,
    input logic [PINS-1:0]   en0_w
);
    logic [ADDR_W-3:0] word;
    assign word = addr[ADDR_W-1:2];

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && pad_oe == '0 && stat_w == '0));

    p_oe_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == '0) |=> (pad_oe[31:0] == $past(wdata)));

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_w & typ_w & ~clr_w) & ~stat_w) == '0));

    p_level_track_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_w & ~$past(typ_w)) == ($past(act_w) & ~$past(typ_w))));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((stat_w & en0_w) != '0));

    p_clear_loses_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hit_w & typ_w) & ~stat_w) == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (int'(word) == 4 || int'(word) == 5 || int'(word) >= 20) |-> (rdata == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .pad_oe (pad_oe),
    .irq    (irq),
    .stat_w (stat_w),
    .typ_w  (typ_w),
    .clr_w  (clr_w),
    .act_w  (act_w),
    .hit_w  (hit_w),
    .en0_w  (en0_w)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_oe, pad_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    logic [31:0] m_cfg [8][2];
    logic [63:0] m_stat, m_s1, m_s2, m_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    function automatic int mbase(input int f);
        int t [9] = '{0, 2, 6, 8, 10, 12, 14, 16, 18};
        return t[f];
    endfunction

    function automatic logic [63:0] mvec(input int f);
        return {m_cfg[f][1], m_cfg[f][0]};
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        int w = int'(a[7:2]);
        for (int f = 0; f < 9; f++)
            if (w >= mbase(f) && w < mbase(f) + 2)
                return (f == 8) ? m_stat[(w - mbase(f))*32 +: 32] : m_cfg[f][w - mbase(f)];
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [63:0] act, pact, hit, clr, typ, pol;
        int wd = int'(a[7:2]);
        typ  = mvec(7);
        pol  = mvec(6);
        act  = m_s2 ^ pol;
        pact = m_sp ^ pol;
        hit  = act & ~pact;
        clr  = '0;
        if (w && (wd == 18 || wd == 19)) clr[(wd-18)*32 +: 32] = d;
        m_stat = (typ & (hit | (m_stat & ~clr))) | (~typ & act);
        if (w)
            for (int f = 0; f < 8; f++)
                if (wd >= mbase(f) && wd < mbase(f) + 2) m_cfg[f][wd - mbase(f)] = d;
        m_sp = m_s2;
        m_s2 = m_s1;
        m_s1 = pad_in;
    endtask

    // called at a negative edge with pad_in already set
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d);
        wr_en = w; addr = a; wdata = d;
        #1;
        chk("R2 readback", {32'h0, rdata}, {32'h0, mread(a)});
        @(posedge clk);
        model_edge(w, a, d);
        @(negedge clk);
        chk("R3 pad_oe", pad_oe, {m_cfg[0][1], m_cfg[0][0]});
        chk("R3 pad_out", pad_out, {m_cfg[1][1], m_cfg[1][0]});
        chk("R8 irq", {63'h0, irq}, {63'h0, |(m_stat & mvec(2))});
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        wr_en = 1'b0; addr = a;
        #1;
        chk(tag, {32'h0, rdata}, {32'h0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 8; f++) begin m_cfg[f][0] = '0; m_cfg[f][1] = '0; end
        m_stat = '0; m_s1 = '0; m_s2 = '0; m_sp = '0;
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 pad_oe", pad_oe, 64'h0);
        chk("R1 pad_out", pad_out, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        for (int w = 0; w < 22; w++) rd("R1 reg zero", 8'(w*4), 32'h0);

        // R2/R3: bank 1 output enable and drive
        step(1, 8'h04, 32'h8000_0001);
        step(1, 8'h0E, 32'h0000_00F0);   // low address bits ignored
        chk("R3 oe bank1", pad_oe, 64'h8000_0001_0000_0000);
        chk("R2 drv bank1", pad_out, 64'h0000_00F0_0000_0000);

        // R4/R5/R6: pin 40 rising edge, bank1 bit 8
        step(1, 8'h44, 32'h100);
        step(1, 8'h1C, 32'h100);
        pad_in[40] = 1'b1;
        step(0, 8'h00, 0);
        rd("R4 not after 1 edge", 8'h4C, 32'h0);
        step(0, 8'h00, 0);
        rd("R4 not after 2 edges", 8'h4C, 32'h0);
        step(0, 8'h00, 0);
        rd("R4 set on 3rd edge", 8'h4C, 32'h100);
        chk("R8 irq from enabled edge", {63'h0, irq}, 64'h1);
        step(1, 8'h4C, 32'hFFFF_FEFF);
        rd("R6 zero bits keep status", 8'h4C, 32'h100);
        step(0, 8'h00, 0);
        rd("R6 sticky while level held", 8'h4C, 32'h100);
        step(1, 8'h4C, 32'h100);
        rd("R6 write one clears", 8'h4C, 32'h0);
        chk("R8 irq drops", {63'h0, irq}, 64'h0);

        // R9: clear lands in the same cycle as a new edge
        pad_in[40] = 1'b0;
        repeat (3) step(0, 8'h00, 0);
        rd("R5 falling ignored when active-high", 8'h4C, 32'h0);
        pad_in[40] = 1'b1;
        step(0, 8'h00, 0);
        step(0, 8'h00, 0);
        step(1, 8'h4C, 32'h100);
        rd("R9 new edge beats clear", 8'h4C, 32'h100);
        step(1, 8'h4C, 32'h100);

        // R5/R7: pin 3 active-low level
        step(1, 8'h38, 32'h8);
        step(0, 8'h00, 0);
        rd("R7 low level sets", 8'h48, 32'h8);
        step(1, 8'h48, 32'h8);
        rd("R7 clear while active holds", 8'h48, 32'h8);
        pad_in[3] = 1'b1;
        step(0, 8'h00, 0);
        step(0, 8'h00, 0);
        rd("R7 still set before level reaches", 8'h48, 32'h8);
        step(0, 8'h00, 0);
        rd("R7 drops with level", 8'h48, 32'h0);

        // R8: enable set two does not feed irq
        step(1, 8'h20, 32'h8);
        pad_in[3] = 1'b0;
        repeat (3) step(0, 8'h00, 0);
        rd("R8 status pending", 8'h48, 32'h8);
        chk("R8 set two ignored", {63'h0, irq}, 64'h0);
        step(1, 8'h18, 32'h8);
        chk("R8 set one drives irq", {63'h0, irq}, 64'h1);

        // R10: unmapped space
        step(1, 8'h10, 32'hFFFF_FFFF);
        step(1, 8'h50, 32'hFFFF_FFFF);
        rd("R10 unmapped 0x10", 8'h10, 32'h0);
        rd("R10 unmapped 0x14", 8'h14, 32'h0);
        rd("R10 unmapped 0x50", 8'h50, 32'h0);
        rd("R10 oe untouched", 8'h00, 32'h0);
        rd("R10 type untouched", 8'h44, 32'h100);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] flip;
            flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            pad_in = pad_in ^ flip;
            step(($urandom % 3) == 0, 8'(($urandom % 22) * 4), $urandom);
            if (i % 7 == 0)
                for (int w = 18; w < 20; w++) rd("R6 R7 status model", 8'(w*4), mread(8'(w*4)));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule